// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 40-bit physical address by reading one 8-byte table entry at each of four table levels. The first table lives at a page-aligned root given by an input, and each entry it reads names the base of the next table, or at the last level the 4 KB frame. A request carries the virtual address, the kind of access (read, write or instruction fetch) and whether it comes from user code. The walker answers with a one-cycle completion pulse. The pulse carries either the physical address or a fault with a two-bit reason.

Before any memory access, the walker rejects addresses that are not sign-extended from bit 47. It then issues one read per level and waits for each response before going on. Every entry it reads is checked for presence, for reserved bits, and for the permission that the access needs. When an entry passes all checks but still has its accessed flag clear, the walker writes the entry back with that flag set, at the same address, before it moves to the next level.

Top module: `pt_walker`

## Requirements
- R1: A virtual address whose bits 63:47 are not all equal completes one cycle after acceptance with fault=1 and fault_code=0, and no memory read or write is issued.
- R2: Level 4 (the first read) is indexed by address bits 47:39, then level 3 by 38:30, level 2 by 29:21 and level 1 by 20:12. Each read address is {table page number, 9-bit index, 3'b000}. The first table page number is root_pfn, and each later one is bits 39:12 of the entry just read.
- R3: Each read is a single-cycle mem_rd_valid pulse. The walker waits for mem_rd_resp before doing anything further, and it issues at most four reads per walk.
- R4: When all four entries pass, done rises with fault=0 and paddr = {bits 39:12 of the fourth entry, virtual address bits 11:0}.
- R5: An entry with bit 0 (present) clear ends the walk with fault_code=1. No further read is issued and that entry is not written.
- R6: An entry that is present but has any of bits 51:40 set ends the walk with fault_code=2.
- R7: A present entry with clean reserved bits gives fault_code=3 if the access is a write (req_kind=1) and entry bit 1 is clear, or if req_user=1 and entry bit 2 is clear.
- R8: An instruction fetch (req_kind=2) through an entry with bit 63 set gives fault_code=3 when nx_en=1. When nx_en=0, bit 63 has no effect. req_kind=0 and req_kind=3 are reads.
- R9: A passing entry with bit 5 (accessed) clear is written back once, as the same value with bit 5 set, before the next read. An entry with bit 5 already set, or a failing entry, is never written.
- R10: After reset req_ready=1, done=0 and both memory strobes are 0. done is a one-cycle pulse, and req_ready is high only while no walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | User-mode access |
| nx_en | input | 1 | Enables the execute-disable bit |
| root_pfn | input | 28 | Page number of the level-4 table |
| mem_rd_valid | output | 1 | Entry read strobe |
| mem_rd_addr | output | 40 | Entry read byte address |
| mem_rd_resp | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Entry read data |
| mem_wr_valid | output | 1 | Entry write strobe |
| mem_wr_addr | output | 40 | Entry write byte address |
| mem_wr_data | output | 64 | Entry write data |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 0 non-canonical, 1 not present, 2 reserved, 3 protection |
| paddr | output | 40 | Translated physical address |

## Verification
A wrong level counter or a wrong held table base shows up as a read address that misses the tables the bench built, and the model catches that at the first wrong level: the resulting entry is not present, so the walk ends with a not-present fault instead of a translation. A wrong held access kind or user flag shows up only when a walk completes, as a different fault code. The bench compares every completion against a model walk over the same memory image, and after each walk it also compares the count of reads, the count of write-backs and the final value of every entry touched. A stuck or doubled accessed-flag write-back therefore appears in the walk where it happens.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [1:0]      req_kind,
  input  logic            req_user,
  input  logic            nx_en,
  input  logic [PA_W-13:0] root_pfn,
  output logic            mem_rd_valid,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_resp,
  input  logic [63:0]     mem_rd_data,
  output logic            mem_wr_valid,
  output logic [PA_W-1:0] mem_wr_addr,
  output logic [63:0]     mem_wr_data,
  output logic            done,
  output logic            fault,
  output logic [1:0]      fault_code,
  output logic [PA_W-1:0] paddr
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_CHK, S_WB} st_t;

  st_t              st;
  logic [1:0]       lvl;
  logic [PA_W-13:0] base;
  logic [47:0]      va;
  logic [1:0]       kind;
  logic             usr, nxe;
  logic [63:0]      ent;

  wire       canon = (&req_vaddr[63:47]) | ~(|req_vaddr[63:47]);
  wire [8:0] idx   = va[12 + 9*lvl +: 9];
  wire [PA_W-1:0] ent_addr = {base, idx, 3'b000};

  wire np   = !ent[0];
  wire rsv  = |ent[51:PA_W];
  wire prot = (kind == 2'b01 && !ent[1]) || (usr && !ent[2]) ||
              (kind == 2'b10 && nxe && ent[63]);
  wire pass = !np && !rsv && !prot;
  wire adv  = (st == S_WB) || (st == S_CHK && pass && ent[5]);

  assign req_ready    = (st == S_IDLE);
  assign mem_rd_valid = (st == S_RD);
  assign mem_rd_addr  = ent_addr;
  assign mem_wr_valid = (st == S_WB);
  assign mem_wr_addr  = ent_addr;
  assign mem_wr_data  = ent | 64'h20;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; lvl <= '0; base <= '0; va <= '0; kind <= '0;
      usr <= 1'b0; nxe <= 1'b0; ent <= '0;
      done <= 1'b0; fault <= 1'b0; fault_code <= '0; paddr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (!canon) begin
            done <= 1'b1; fault <= 1'b1; fault_code <= 2'd0;
          end else begin
            va <= req_vaddr[47:0]; kind <= req_kind; usr <= req_user;
            nxe <= nx_en; base <= root_pfn; lvl <= 2'd3; st <= S_RD;
          end
        end
        S_RD:   st <= S_WAIT;
        S_WAIT: if (mem_rd_resp) begin
          ent <= mem_rd_data; st <= S_CHK;
        end
        S_CHK: begin
          if (!pass) begin
            done <= 1'b1; fault <= 1'b1; st <= S_IDLE;
            fault_code <= np ? 2'd1 : rsv ? 2'd2 : 2'd3;
          end else if (!ent[5]) st <= S_WB;
        end
        default: ;
      endcase
      if (adv) begin
        if (lvl == 2'd0) begin
          done <= 1'b1; fault <= 1'b0; st <= S_IDLE;
          paddr <= {ent[PA_W-1:12], va[11:0]};
        end else begin
          base <= ent[PA_W-1:12]; lvl <= lvl - 2'd1; st <= S_RD;
        end
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_vaddr,
  input logic        mem_rd_valid,
  input logic        mem_wr_valid,
  input logic [63:0] mem_wr_data,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_code
);
  assert_noncanon_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !((&req_vaddr[63:47]) || !(|req_vaddr[63:47])))
      |=> (done && fault && fault_code == 2'd0 && !mem_rd_valid));

  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  assert_wb_sets_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_data[5] && !mem_rd_valid));

  assert_wb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |=> !mem_wr_valid);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_no_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || mem_wr_valid) |-> !req_ready);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .mem_rd_valid(mem_rd_valid), .mem_wr_valid(mem_wr_valid),
  .mem_wr_data(mem_wr_data), .done(done), .fault(fault), .fault_code(fault_code)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_user = 0, nx_en = 0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [27:0] root_pfn = '0;
  logic        req_ready, mem_rd_valid, mem_wr_valid, done, fault;
  logic        mem_rd_resp = 0;
  logic [63:0] mem_rd_data = '0, mem_wr_data;
  logic [39:0] mem_rd_addr, mem_wr_addr, paddr;
  logic [1:0]  fault_code;

  pt_walker uut (.*);

  always #(PERIOD/2) clk = ~clk;

  logic [63:0] mem [logic [39:0]];
  int nrd, nwr, errors, checks;
  logic [39:0] exp_addr [4];
  logic [63:0] exp_val [4];
  logic [63:0] lvl_fl [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder, driven away from the active edge
  initial begin
    logic pend; int dly; logic [39:0] a;
    pend = 0; dly = 0; a = '0;
    forever begin
      @(negedge clk);
      mem_rd_resp = 0;
      if (mem_wr_valid) begin mem[mem_wr_addr] = mem_wr_data; nwr++; end
      if (pend) begin
        if (dly == 0) begin
          mem_rd_resp = 1;
          mem_rd_data = mem.exists(a) ? mem[a] : 64'h0;
          pend = 0;
        end else dly--;
      end
      if (mem_rd_valid) begin pend = 1; a = mem_rd_addr; dly = $urandom_range(0, 2); nrd++; end
    end
  end

  initial begin
    #(PERIOD*150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  function automatic logic [63:0] rd_mem(input logic [39:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // builds a path whose level-L entry (L=3 first) is lvl_fl[3-L] plus its next page number
  task automatic build(input logic [63:0] va, input logic [27:0] root);
    logic [27:0] b;
    b = root;
    mem.delete();
    for (int l = 3; l >= 0; l--) begin
      logic [27:0] nx;
      logic [63:0] e;
      nx = 28'($urandom);
      e = lvl_fl[3-l];
      e[39:12] = nx;
      mem[{b, va[12+9*l +: 9], 3'b000}] = e;
      b = nx;
    end
  endtask

  function automatic void model(input logic [63:0] va, input logic [1:0] kind,
      input logic usr, input logic nxe, input logic [27:0] root,
      output logic f, output logic [1:0] c, output logic [39:0] pa,
      output int nr, output int nw);
    logic [27:0] b;
    logic [63:0] e;
    f = 0; c = 0; pa = '0; nr = 0; nw = 0; b = root; e = '0;
    if (!((&va[63:47]) || !(|va[63:47]))) begin f = 1; c = 0; return; end
    for (int l = 3; l >= 0; l--) begin
      logic [39:0] a;
      a = {b, va[12+9*l +: 9], 3'b000};
      e = rd_mem(a);
      exp_addr[nr] = a; exp_val[nr] = e; nr++;
      if (!e[0]) begin f = 1; c = 1; return; end
      if (|e[51:40]) begin f = 1; c = 2; return; end
      if ((kind == 2'd1 && !e[1]) || (usr && !e[2]) || (kind == 2'd2 && nxe && e[63])) begin
        f = 1; c = 3; return;
      end
      if (!e[5]) begin nw++; exp_val[nr-1] = e | 64'h20; end
      b = e[39:12];
    end
    pa = {e[39:12], va[11:0]};
  endfunction

  task automatic run(input logic [63:0] va, input logic [1:0] kind, input logic usr,
                     input logic nxe, input logic [27:0] root, input string tag);
    logic ef; logic [1:0] ec; logic [39:0] ep; int er, ew;
    model(va, kind, usr, nxe, root, ef, ec, ep, er, ew);
    nrd = 0; nwr = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_vaddr = va; req_kind = kind; req_user = usr; nx_en = nxe; root_pfn = root;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    check(fault == ef, tag, "fault", 64'(fault), 64'(ef));
    if (ef) check(fault_code == ec, tag, "fault_code", 64'(fault_code), 64'(ec));
    else    check(paddr == ep, "R4", "paddr", 64'(paddr), 64'(ep));
    @(negedge clk);
    check(!done, "R10", "done pulse", 64'(done), 64'h0);
    check(nrd == er, "R3", "read count", 64'(nrd), 64'(er));
    check(nwr == ew, "R9", "writeback count", 64'(nwr), 64'(ew));
    for (int i = 0; i < er; i++)
      check(rd_mem(exp_addr[i]) == exp_val[i], "R9", "entry after walk",
            rd_mem(exp_addr[i]), exp_val[i]);
  endtask

  localparam logic [63:0] OK_A  = 64'h27;   // present, writable, user, accessed
  localparam logic [63:0] OK_NA = 64'h07;   // same, accessed clear

  initial begin
    void'($urandom(32'h5eed));
    errors = 0; checks = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready == 1 && done == 0 && mem_rd_valid == 0 && mem_wr_valid == 0,
          "R10", "reset outputs", {req_ready, done, mem_rd_valid, mem_wr_valid}, 4'b1000);
    rst_n = 1;

    // R1 non-canonical: bit 47 set, upper bits clear
    for (int i = 0; i < 4; i++) lvl_fl[i] = OK_A;
    build(64'h0000_8000_0000_0000, 28'h123);
    run(64'h0000_8000_0000_0000, 2'd0, 0, 0, 28'h123, "R1");
    // R1/R2/R4 boundary canonical addresses
    build(64'hFFFF_8000_0000_0ABC, 28'h456);
    run(64'hFFFF_8000_0000_0ABC, 2'd1, 1, 1, 28'h456, "R2");
    build(64'h0000_7FFF_FFFF_FFFF, 28'h789);
    run(64'h0000_7FFF_FFFF_FFFF, 2'd0, 0, 0, 28'h789, "R2");
    // R9 all accessed clear
    for (int i = 0; i < 4; i++) lvl_fl[i] = OK_NA;
    build(64'h0000_1234_5678_9ABC, 28'h0AB);
    run(64'h0000_1234_5678_9ABC, 2'd2, 0, 1, 28'h0AB, "R9");
    // R5 not present at level 2
    for (int i = 0; i < 4; i++) lvl_fl[i] = OK_NA;
    lvl_fl[2] = 64'h26;
    build(64'h0000_0000_DEAD_B000, 28'h0CD);
    run(64'h0000_0000_DEAD_B000, 2'd0, 0, 0, 28'h0CD, "R5");
    // R6 reserved bit 40 set at level 3
    lvl_fl[2] = OK_A; lvl_fl[1] = 64'h0000_0100_0000_0027;
    build(64'h0000_0000_DEAD_B000, 28'h0CE);
    run(64'h0000_0000_DEAD_B000, 2'd0, 0, 0, 28'h0CE, "R6");
    // R7 write through read-only level 1, user through supervisor level 4
    for (int i = 0; i < 4; i++) lvl_fl[i] = OK_A;
    lvl_fl[3] = 64'h25;
    build(64'h0000_0042_0000_0000, 28'h0EF);
    run(64'h0000_0042_0000_0000, 2'd1, 0, 0, 28'h0EF, "R7");
    lvl_fl[3] = OK_A; lvl_fl[0] = 64'h23;
    build(64'h0000_0042_0000_0000, 28'h0F0);
    run(64'h0000_0042_0000_0000, 2'd0, 1, 0, 28'h0F0, "R7");
    // R8 execute-disable, with and without the enable
    for (int i = 0; i < 4; i++) lvl_fl[i] = OK_A;
    lvl_fl[1] = 64'h8000_0000_0000_0027;
    build(64'h0000_0011_2233_4000, 28'h0F1);
    run(64'h0000_0011_2233_4000, 2'd2, 0, 1, 28'h0F1, "R8");
    run(64'h0000_0011_2233_4000, 2'd2, 0, 0, 28'h0F1, "R8");
    run(64'h0000_0011_2233_4000, 2'd3, 0, 1, 28'h0F1, "R8");

    // random walks
    for (int t = 0; t < 300; t++) begin
      logic [63:0] va; logic [27:0] root;
      va = {$urandom, $urandom};
      if ($urandom_range(0, 9) != 0) va[63:47] = {17{va[47]}};
      for (int i = 0; i < 4; i++) begin
        logic [63:0] e;
        e = '0;
        e[0] = ($urandom_range(0, 19) != 0);
        e[1] = ($urandom_range(0, 4) != 0);
        e[2] = ($urandom_range(0, 4) != 0);
        e[5] = $urandom_range(0, 1);
        e[63] = ($urandom_range(0, 4) == 0);
        if ($urandom_range(0, 24) == 0) e[51:40] = 12'($urandom_range(1, 4095));
        lvl_fl[i] = e;
      end
      root = 28'($urandom);
      build(va, root);
      run(va, 2'($urandom), 1'($urandom), 1'($urandom), root, "R2");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule